// File: doc/BRIEF.md
# Linear CCD clock timing generator

This block makes the digital drive waveforms for a three-color linear CCD sensor. The sensor has one odd-pixel and one even-pixel readout channel per color, and all six channels are clocked in phase from one set of signals. A line starts with a request pulse. The block parks the shift clocks, fires the transfer-gate pulse, and then clocks every pixel slot of the line out of the shift registers. Each slot gets a reset-gate pulse and, when selected, a clamp pulse.

Every width and gap is a count of system-clock cycles taken from configuration inputs. The counts are raised to their minimums and latched when the line starts, so the timing cannot change while a line is running. Downstream capture logic gets a one-cycle strobe at the start of each pixel slot. The strobe says whether the pixel is a dummy (register or invalid) pixel, an optical-black pixel or a valid pixel. In the default build each channel has 13 register pixels, then 48 black, 3 invalid, 3650 valid and 3 invalid pixels.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, and whenever no line is running, every output is low. The block stays idle until `line_req` is sampled high.
- R2: When `line_req` is sampled high while idle, `busy` and `sh_p1` go high in the next cycle. `xfer_gate` rises S cycles after that, where S is the effective setup count. It stays high for X cycles, where X is the effective transfer count. The first readout edge comes S cycles after `xfer_gate` falls.
- R3: Through the setup windows and the transfer pulse, `sh_p1` is high and `sh_p2` is low and both stay static. `rst_gate` and `clamp_pulse` are low for that whole time.
- R4: Readout has NPIX slots of 2H cycles each, where H is the effective half-period. In each slot `sh_p2` is high for the first H cycles and `sh_p1` is high for the last H cycles. `sh_p2_last` equals `sh_p2`, and `sh_p1` and `sh_p2` are never equal while busy.
- R5: `rst_gate` is high for the first Rw cycles of every slot, where Rw is the effective reset width.
- R6: With `clamp_line` = 0 (bit clamp), `clamp_pulse` rises Rw+G cycles into each slot and stays high for C cycles. G is the effective clamp gap and C is the effective clamp width.
- R7: With `clamp_line` = 1 (line clamp), `clamp_pulse` stays low for the whole line.
- R8: Exactly one strobe fires, for one cycle, in the first cycle of each slot. Slot order is N_REG dummy, N_BLACK black, N_LEAD dummy, N_VALID valid, then N_TRAIL dummy.
- R9: A configured count below its minimum (MIN_SETUP, MIN_XFER, MIN_RST, MIN_GAP, MIN_CLAMP) is replaced by the minimum. H is the larger of `cfg_half` and Rw+G+C.
- R10: The configuration inputs and `clamp_line` are latched at line start. Changing them during a line has no effect on that line.
- R11: A `line_req` that arrives during a line is ignored. After the last slot every output returns low, and the next request starts a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_req | input | 1 | Line start request |
| clamp_line | input | 1 | 0 = clamp every pixel, 1 = no clamp during readout |
| cfg_setup | input | CW | Gap between a shift-clock edge and a transfer-gate edge, in cycles |
| cfg_xfer | input | CW | Transfer-gate high width, in cycles |
| cfg_half | input | CW | Shift clock half-period, in cycles |
| cfg_rst | input | CW | Reset-gate high width, in cycles |
| cfg_gap | input | CW | Reset fall to clamp rise, in cycles |
| cfg_clamp | input | CW | Clamp high width, in cycles |
| busy | output | 1 | A line is running |
| xfer_gate | output | 1 | Transfer-gate pulse |
| sh_p1 | output | 1 | Shift clock phase 1 |
| sh_p2 | output | 1 | Shift clock phase 2 |
| sh_p2_last | output | 1 | Last-stage shift clock |
| rst_gate | output | 1 | Reset-gate clock |
| clamp_pulse | output | 1 | Clamp clock |
| pix_dummy | output | 1 | Slot-start strobe, dummy pixel |
| pix_black | output | 1 | Slot-start strobe, optical-black pixel |
| pix_valid | output | 1 | Slot-start strobe, valid pixel |

## Verification
The assertions cover the invariants on every cycle:
- outputs quiet when idle
- shift clocks parked, with reset and clamp low, under the transfer pulse
- complementary phases while busy
- reset and clamp never overlapping
- no clamp in line-clamp mode
- at most one region strobe, and it lands on a reset pulse
- latched mode steady during a line

The exact cycle counts cannot be expressed as simple properties and are left to the bench scenarios: the setup and transfer lengths, slot length, clamp placement, clamping to the minimums, region order, and the ignored mid-line request and configuration change. The bench sweeps these against an arithmetic model of the whole line.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int CW        = 12,
  parameter int N_REG     = 13,
  parameter int N_BLACK   = 48,
  parameter int N_LEAD    = 3,
  parameter int N_VALID   = 3650,
  parameter int N_TRAIL   = 3,
  parameter int MIN_SETUP = 2,
  parameter int MIN_XFER  = 4,
  parameter int MIN_RST   = 1,
  parameter int MIN_GAP   = 1,
  parameter int MIN_CLAMP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_req,
  input  logic          clamp_line,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_xfer,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rst,
  input  logic [CW-1:0] cfg_gap,
  input  logic [CW-1:0] cfg_clamp,
  output logic          busy,
  output logic          xfer_gate,
  output logic          sh_p1,
  output logic          sh_p2,
  output logic          sh_p2_last,
  output logic          rst_gate,
  output logic          clamp_pulse,
  output logic          pix_dummy,
  output logic          pix_black,
  output logic          pix_valid
);
  localparam int NPIX = N_REG + N_BLACK + N_LEAD + N_VALID + N_TRAIL;
  localparam int PW   = $clog2(NPIX + 1);
  localparam int TW   = CW + 3;
  localparam int B1   = N_REG;
  localparam int B2   = B1 + N_BLACK;
  localparam int B3   = B2 + N_LEAD;
  localparam int B4   = B3 + N_VALID;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_XFER, S_POST, S_READ} st_t;

  function automatic logic [TW-1:0] raise(input logic [CW-1:0] v, input int m);
    logic [TW-1:0] w;
    w = TW'(v);
    return (w < TW'(m)) ? TW'(m) : w;
  endfunction

  st_t            st;
  logic [TW-1:0]  cnt;
  logic [PW-1:0]  pix;
  logic [TW-1:0]  q_setup, q_xfer, q_half, q_rst, q_gap, q_clamp;
  logic           q_line;

  logic [TW-1:0]  e_rst, e_gap, e_clamp, e_sum, e_half;
  assign e_rst   = raise(cfg_rst, MIN_RST);
  assign e_gap   = raise(cfg_gap, MIN_GAP);
  assign e_clamp = raise(cfg_clamp, MIN_CLAMP);
  assign e_sum   = e_rst + e_gap + e_clamp;
  assign e_half  = (TW'(cfg_half) < e_sum) ? e_sum : TW'(cfg_half);

  logic [TW-1:0] slot_last, cp_on, cp_off;
  assign slot_last = (q_half << 1) - TW'(1);
  assign cp_on     = q_rst + q_gap;
  assign cp_off    = cp_on + q_clamp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      pix     <= '0;
      q_setup <= '0;
      q_xfer  <= '0;
      q_half  <= '0;
      q_rst   <= '0;
      q_gap   <= '0;
      q_clamp <= '0;
      q_line  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (line_req) begin
          q_setup <= raise(cfg_setup, MIN_SETUP);
          q_xfer  <= raise(cfg_xfer, MIN_XFER);
          q_rst   <= e_rst;
          q_gap   <= e_gap;
          q_clamp <= e_clamp;
          q_half  <= e_half;
          q_line  <= clamp_line;
          cnt     <= '0;
          st      <= S_PRE;
        end
        S_PRE: if (cnt == q_setup - TW'(1)) begin
          cnt <= '0;
          st  <= S_XFER;
        end else cnt <= cnt + TW'(1);
        S_XFER: if (cnt == q_xfer - TW'(1)) begin
          cnt <= '0;
          st  <= S_POST;
        end else cnt <= cnt + TW'(1);
        S_POST: if (cnt == q_setup - TW'(1)) begin
          cnt <= '0;
          pix <= '0;
          st  <= S_READ;
        end else cnt <= cnt + TW'(1);
        S_READ: if (cnt == slot_last) begin
          cnt <= '0;
          if (pix == PW'(NPIX - 1)) st <= S_IDLE;
          else pix <= pix + PW'(1);
        end else cnt <= cnt + TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  logic rd, park, head, in_black, in_valid;
  assign rd   = (st == S_READ);
  assign park = (st == S_PRE) || (st == S_XFER) || (st == S_POST);
  assign head = rd && (cnt == '0);
  assign in_black = (pix >= PW'(B1)) && (pix < PW'(B2));
  assign in_valid = (pix >= PW'(B3)) && (pix < PW'(B4));

  assign busy        = (st != S_IDLE);
  assign xfer_gate   = (st == S_XFER);
  assign sh_p2       = rd && (cnt < q_half);
  assign sh_p1       = park || (rd && (cnt >= q_half));
  assign sh_p2_last  = sh_p2;
  assign rst_gate    = rd && (cnt < q_rst);
  assign clamp_pulse = rd && !q_line && (cnt >= cp_on) && (cnt < cp_off);
  assign pix_black   = head && in_black;
  assign pix_valid   = head && in_valid;
  assign pix_dummy   = head && !in_black && !in_valid;
endmodule

module ccd_line_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic line_req,
  input logic q_line,
  input logic busy,
  input logic xfer_gate,
  input logic sh_p1,
  input logic sh_p2,
  input logic sh_p2_last,
  input logic rst_gate,
  input logic clamp_pulse,
  input logic pix_dummy,
  input logic pix_black,
  input logic pix_valid
);
  logic any_stb;
  assign any_stb = pix_dummy | pix_black | pix_valid;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(xfer_gate | sh_p1 | sh_p2 | sh_p2_last | rst_gate | clamp_pulse | any_stb));

  a_r2_gate_after_park: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_gate) |-> $past(sh_p1) && $past(busy) && !$past(line_req && !busy));

  a_r3_gate_parked: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> sh_p1 && !sh_p2 && !rst_gate && !clamp_pulse);

  a_r3_tail_parked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_gate) |-> sh_p1 && !sh_p2 && !rst_gate && busy);

  a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sh_p1 != sh_p2));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_gate && clamp_pulse));

  a_r7_line_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && q_line) |-> !clamp_pulse);

  a_r8_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_dummy, pix_black, pix_valid}));

  a_r5_strobe_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> rst_gate && sh_p2);

  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(q_line));
endmodule

bind ccd_line_timer ccd_line_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .line_req(line_req), .q_line(q_line),
  .busy(busy), .xfer_gate(xfer_gate), .sh_p1(sh_p1), .sh_p2(sh_p2),
  .sh_p2_last(sh_p2_last), .rst_gate(rst_gate), .clamp_pulse(clamp_pulse),
  .pix_dummy(pix_dummy), .pix_black(pix_black), .pix_valid(pix_valid)
);

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;
  localparam int CLK_NS = 10;
  localparam int CW = 6;
  localparam int NR = 2, NB = 3, NL = 1, NV = 4, NT = 1;
  localparam int NPIX = NR + NB + NL + NV + NT;
  localparam int MS = 2, MX = 3, MR = 1, MG = 1, MC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_req = 1'b0;
  logic clamp_line = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_xfer = '0, cfg_half = '0;
  logic [CW-1:0] cfg_rst = '0, cfg_gap = '0, cfg_clamp = '0;
  logic busy, xfer_gate, sh_p1, sh_p2, sh_p2_last, rst_gate, clamp_pulse;
  logic pix_dummy, pix_black, pix_valid;

  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  ccd_line_timer #(
    .CW(CW), .N_REG(NR), .N_BLACK(NB), .N_LEAD(NL), .N_VALID(NV), .N_TRAIL(NT),
    .MIN_SETUP(MS), .MIN_XFER(MX), .MIN_RST(MR), .MIN_GAP(MG), .MIN_CLAMP(MC)
  ) i_ccd_line_timer (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .clamp_line(clamp_line),
    .cfg_setup(cfg_setup), .cfg_xfer(cfg_xfer), .cfg_half(cfg_half),
    .cfg_rst(cfg_rst), .cfg_gap(cfg_gap), .cfg_clamp(cfg_clamp),
    .busy(busy), .xfer_gate(xfer_gate), .sh_p1(sh_p1), .sh_p2(sh_p2),
    .sh_p2_last(sh_p2_last), .rst_gate(rst_gate), .clamp_pulse(clamp_pulse),
    .pix_dummy(pix_dummy), .pix_black(pix_black), .pix_valid(pix_valid)
  );

  function automatic int up(int v, int m);
    return (v < m) ? m : v;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0d got %0b exp %0b", tag, cur_t, got, exp);
    end
  endtask

  task automatic check_idle(string tag);
    chk({tag, " busy"}, busy, 1'b0);
    chk({tag, " gate"}, xfer_gate, 1'b0);
    chk({tag, " p1"}, sh_p1, 1'b0);
    chk({tag, " p2"}, sh_p2, 1'b0);
    chk({tag, " p2last"}, sh_p2_last, 1'b0);
    chk({tag, " rst"}, rst_gate, 1'b0);
    chk({tag, " clamp"}, clamp_pulse, 1'b0);
    chk({tag, " strobes"}, pix_dummy | pix_black | pix_valid, 1'b0);
  endtask

  task automatic run_line(int s, int x, int h, int r, int g, int c, bit m,
                          bit disturb, string lt);
    int es, ex, er, eg, ec, eh, len;
    es = up(s, MS); ex = up(x, MX); er = up(r, MR); eg = up(g, MG); ec = up(c, MC);
    eh = up(h, er + eg + ec);
    len = 2 * es + ex + NPIX * 2 * eh;
    cfg_setup = CW'(s); cfg_xfer = CW'(x); cfg_half = CW'(h);
    cfg_rst = CW'(r); cfg_gap = CW'(g); cfg_clamp = CW'(c);
    clamp_line = m;
    line_req = 1'b1;
    for (int t = 0; t < len + 3; t++) begin
      @(negedge clk);
      cur_t = t;
      if (t == 0) line_req = 1'b0;
      if (t >= len) check_idle({"R11 end ", lt});
      else begin
        logic e_busy, e_gate, e_p1, e_p2, e_rst, e_cp, e_d, e_b, e_v;
        e_busy = 1'b1; e_gate = 1'b0; e_p1 = 1'b1; e_p2 = 1'b0;
        e_rst = 1'b0; e_cp = 1'b0; e_d = 1'b0; e_b = 1'b0; e_v = 1'b0;
        if (t >= es && t < es + ex) e_gate = 1'b1;
        if (t >= 2 * es + ex) begin
          int u, p, k;
          u = t - (2 * es + ex);
          p = u / (2 * eh);
          k = u % (2 * eh);
          e_p2 = (k < eh);
          e_p1 = !e_p2;
          e_rst = (k < er);
          e_cp = !m && (k >= er + eg) && (k < er + eg + ec);
          if (k == 0) begin
            if (p >= NR && p < NR + NB) e_b = 1'b1;
            else if (p >= NR + NB + NL && p < NR + NB + NL + NV) e_v = 1'b1;
            else e_d = 1'b1;
          end
        end
        chk({"R2 busy ", lt}, busy, e_busy);
        chk({"R2 gate ", lt}, xfer_gate, e_gate);
        chk({"R3 R4 p1 ", lt}, sh_p1, e_p1);
        chk({"R3 R4 p2 ", lt}, sh_p2, e_p2);
        chk({"R4 p2last ", lt}, sh_p2_last, e_p2);
        chk({"R3 R5 rst ", lt}, rst_gate, e_rst);
        if (m) chk({"R7 clamp ", lt}, clamp_pulse, e_cp);
        else   chk({"R6 clamp ", lt}, clamp_pulse, e_cp);
        chk({"R8 dummy ", lt}, pix_dummy, e_d);
        chk({"R8 black ", lt}, pix_black, e_b);
        chk({"R8 valid ", lt}, pix_valid, e_v);
      end
      if (disturb && t == 3) begin
        line_req = 1'b1;
        cfg_setup = CW'(s + 3); cfg_xfer = CW'(x + 5); cfg_half = CW'(h + 4);
        cfg_rst = CW'(r + 2); cfg_gap = CW'(g + 1); cfg_clamp = CW'(c + 2);
        clamp_line = !m;
      end
      if (disturb && t == 5) line_req = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_idle("R1 after reset");
    end
    run_line(2, 3, 4, 1, 1, 1, 1'b0, 1'b0, "base");
    run_line(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R9 zeros");
    run_line(5, 7, 2, 2, 1, 3, 1'b0, 1'b0, "R9 half raised");
    run_line(3, 4, 5, 1, 2, 1, 1'b1, 1'b0, "line clamp");
    run_line(1, 9, 8, 3, 1, 2, 1'b0, 1'b1, "R10 R11 disturbed bit");
    run_line(4, 3, 3, 1, 1, 1, 1'b1, 1'b1, "R10 R11 disturbed line");
    run_line(2, 4, 7, 2, 2, 2, 1'b0, 1'b0, "R11 restart");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule